// File: doc/BRIEF.md
# Temperature Linearizer and Scaler

This block turns the ratio word produced by a sensor decimation stage into a temperature. The ratio X is non-linear in temperature. The block first forms the fraction mu = alpha / (alpha + X), where alpha is a calibration constant; mu is close to linear in temperature. It then maps mu to degrees Celsius as A·mu + B, with a calibration gain A and a signed offset B.

A ratio enters through a valid/ready handshake. The three calibration values are plain input buses. They are captured together with the ratio when a conversion starts, so they can be rewritten at any time without disturbing a result in flight. The division uses a bit-serial restoring divider that produces one quotient bit per clock. A single multiply-round-add stage follows it. The result appears on a one-cycle valid pulse and is held until the next result.

Top module: `tconv_linearizer`

## Requirements
- R1: After reset, outValid is 0, inReady is 1 and tempOut is 0.
- R2: A ratio is taken on a rising edge where inValid and inReady are both 1. inReady is 0 from the next cycle until the cycle in which the result is presented.
- R3: outValid is 1 for exactly one cycle. That cycle is the 18th rising edge after acceptance. inReady is 1 again in that same cycle.
- R4: Codes: ratioIn is unsigned Q2.14 and alphaIn is unsigned Q6.10. The linear fraction is the unsigned Q1.16 code mu = floor(alpha·2^20 / (16·alpha + x)), where alpha and x are the raw codes.
- R5: gainIn is unsigned Q10.6 and offsetIn is two's-complement Q10.6. tempOut is two's-complement Q10.6 and equals offset + floor((gain·mu + 2^15) / 2^16), using raw codes (round half up).
- R6: For nominal calibration (alpha 16, gain 610, offset −283) and ratios from 0.15 to 0.72, tempOut is within 1.5 LSB of the real-valued A·alpha/(alpha+X)+B.
- R7: With alphaIn = 0 and a non-zero ratio, tempOut equals offsetIn exactly. With ratioIn = 0 and a non-zero alpha, tempOut equals gain + offset.
- R8: A sum above 32767 (0x7FFF) is clamped to 32767 instead of wrapping. A negative result occurs only when the offset is negative.
- R9: inValid asserted while a conversion is running is not accepted. It does not change the running result.
- R10: Changes on alphaIn, gainIn or offsetIn after acceptance do not affect that conversion. The next conversion uses the new values.
- R11: tempOut holds its value from one result until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Ratio word offered |
| inReady | output | 1 | Block idle, ratio can be taken |
| ratioIn | input | 16 | Ratio X, unsigned Q2.14 |
| alphaIn | input | 16 | Calibration alpha, unsigned Q6.10 |
| gainIn | input | 16 | Calibration gain A, unsigned Q10.6 |
| offsetIn | input | 16 | Calibration offset B, signed Q10.6 |
| outValid | output | 1 | One-cycle result strobe |
| tempOut | output | 16 | Temperature, signed Q10.6 |

## Verification
The main path is driven with ratios spread across the nominal sensor span under two calibration sets. Each result is compared bit-exactly with the integer formula and also, for tolerance, with a real-valued model; this separates a wrong alignment or rounding from plain quantisation. Ratios at zero, above 1.0 and near the top of the Q2.14 range exercise the quotient's integer bit and very small quotients. A zero alpha, a saturating gain/offset pair, inputs offered while busy, and calibration changes during a conversion each target one mistake in the control or capture logic.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_MAP  = 2'd2
  } convState_t;

  typedef struct packed {
    logic load;
    logic step;
    logic map;
  } ctlStrobe_t;

endpackage

// File: rtl/tconv_ctrl.sv
module tconv_ctrl
  import tconv_pkg::*;
#(
  parameter int Q_W = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  output ctlStrobe_t ctl
);

  localparam int CNT_W = $clog2(Q_W);
  localparam int LAT   = Q_W + 1;
  localparam int LC_W  = $clog2(LAT + 2);

  convState_t state;
  logic [CNT_W-1:0] bitCnt;

  assign inReady  = (state == ST_IDLE);
  assign ctl.load = (state == ST_IDLE) && inValid;
  assign ctl.step = (state == ST_DIV);
  assign ctl.map  = (state == ST_MAP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= 1'b0;
      case (state)
        ST_IDLE: if (inValid) begin
          state  <= ST_DIV;
          bitCnt <= CNT_W'(Q_W - 1);
        end
        ST_DIV: if (bitCnt == '0) state <= ST_MAP;
                else bitCnt <= bitCnt - 1'b1;
        ST_MAP: begin
          state    <= ST_IDLE;
          outValid <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Latency watch counter, used only by the checks below
  logic [LC_W-1:0] latCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latCnt <= '0;
    else if (inValid && inReady) latCnt <= LC_W'(1);
    else if (outValid) latCnt <= '0;
    else if (latCnt != '0) latCnt <= latCnt + 1'b1;
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R3
  ready_with_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (latCnt == LC_W'(LAT + 1)));

endmodule

// File: rtl/tconv_dp.sv
module tconv_dp
  import tconv_pkg::*;
#(
  parameter int X_W        = 16,
  parameter int X_FRAC     = 14,
  parameter int ALPHA_W    = 16,
  parameter int ALPHA_FRAC = 10,
  parameter int GAIN_W     = 16,
  parameter int OFF_W      = 16,
  parameter int OUT_W      = 16,
  parameter int MU_FRAC    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [X_W-1:0]   ratioIn,
  input  logic [ALPHA_W-1:0] alphaIn,
  input  logic [GAIN_W-1:0]  gainIn,
  input  logic [OFF_W-1:0]   offsetIn,
  output logic [OUT_W-1:0]   tempOut
);

  localparam int ALIGN  = X_FRAC - ALPHA_FRAC;
  localparam int NUM_W  = (ALPHA_W + ALIGN > X_W) ? ALPHA_W + ALIGN : X_W;
  localparam int DEN_W  = NUM_W + 1;
  localparam int REM_W  = DEN_W + 1;
  localparam int Q_W    = MU_FRAC + 1;
  localparam int PROD_W = GAIN_W + Q_W;
  localparam int RND_W  = PROD_W + 1 - MU_FRAC;
  localparam int SUM_W  = RND_W + 2;
  localparam logic signed [SUM_W-1:0] MAX_POS = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_NEG = -SUM_W'(1 << (OUT_W - 1));

  // Alpha aligned to the ratio's binary point
  logic [NUM_W-1:0] alphaAligned;
  generate
    if (ALIGN > 0) begin : g_shift
      assign alphaAligned = NUM_W'({alphaIn, {ALIGN{1'b0}}});
    end else begin : g_direct
      assign alphaAligned = NUM_W'(alphaIn);
    end
  endgenerate

  logic [DEN_W-1:0]  denomReg;
  logic [REM_W-1:0]  remReg;
  logic [Q_W-1:0]    quotReg;
  logic [GAIN_W-1:0] gainReg;
  logic [OFF_W-1:0]  offReg;

  // Restoring step
  logic [REM_W-1:0] denomExt, diff, remNext;
  logic             geBit;
  always_comb begin
    denomExt = {1'b0, denomReg};
    geBit    = (remReg >= denomExt);
    diff     = remReg - denomExt;
    remNext  = geBit ? {diff[REM_W-2:0], 1'b0} : {remReg[REM_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      denomReg <= '0;
      remReg   <= '0;
      quotReg  <= '0;
      gainReg  <= '0;
      offReg   <= '0;
    end else if (ctl.load) begin
      denomReg <= DEN_W'(alphaAligned) + DEN_W'(ratioIn);
      remReg   <= REM_W'(alphaAligned);
      quotReg  <= '0;
      gainReg  <= gainIn;
      offReg   <= offsetIn;
    end else if (ctl.step) begin
      remReg  <= remNext;
      quotReg <= {quotReg[Q_W-2:0], geBit};
    end
  end

  // Scale, round half up, add offset, clamp
  logic [PROD_W-1:0]       prod;
  logic [PROD_W:0]         prodRnd;
  logic [RND_W-1:0]        scaled;
  logic signed [SUM_W-1:0] sum;
  logic [OUT_W-1:0]        clamped;
  always_comb begin
    prod    = PROD_W'(gainReg) * PROD_W'(quotReg);
    prodRnd = {1'b0, prod} + (PROD_W+1)'(1 << (MU_FRAC - 1));
    scaled  = prodRnd[PROD_W:MU_FRAC];
    sum     = $signed({2'b00, scaled})
            + $signed({{(SUM_W-OFF_W){offReg[OFF_W-1]}}, offReg});
    if (sum > MAX_POS)      clamped = MAX_POS[OUT_W-1:0];
    else if (sum < MIN_NEG) clamped = MIN_NEG[OUT_W-1:0];
    else                    clamped = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tempOut <= '0;
    else if (ctl.map) tempOut <= clamped;
  end

  // R4
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && denomReg != '0) |-> (remReg < {denomReg, 1'b0}));

  // R10
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(gainReg) && $stable(offReg) && $stable(denomReg)));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.map |=> $stable(tempOut));

  // R8
  sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.map |=> (!tempOut[OUT_W-1] || offReg[OFF_W-1]));

endmodule

// File: rtl/tconv_linearizer.sv
module tconv_linearizer
  import tconv_pkg::*;
#(
  parameter int X_W        = 16,
  parameter int X_FRAC     = 14,
  parameter int ALPHA_W    = 16,
  parameter int ALPHA_FRAC = 10,
  parameter int GAIN_W     = 16,
  parameter int OFF_W      = 16,
  parameter int OUT_W      = 16,
  parameter int MU_FRAC    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [X_W-1:0]     ratioIn,
  input  logic [ALPHA_W-1:0] alphaIn,
  input  logic [GAIN_W-1:0]  gainIn,
  input  logic [OFF_W-1:0]   offsetIn,
  output logic               outValid,
  output logic [OUT_W-1:0]   tempOut
);

  localparam int Q_W = MU_FRAC + 1;

  ctlStrobe_t ctl;

  tconv_ctrl #(.Q_W(Q_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  tconv_dp #(
    .X_W(X_W), .X_FRAC(X_FRAC), .ALPHA_W(ALPHA_W), .ALPHA_FRAC(ALPHA_FRAC),
    .GAIN_W(GAIN_W), .OFF_W(OFF_W), .OUT_W(OUT_W), .MU_FRAC(MU_FRAC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .ratioIn  (ratioIn),
    .alphaIn  (alphaIn),
    .gainIn   (gainIn),
    .offsetIn (offsetIn),
    .tempOut  (tempOut)
  );

endmodule

// File: tb/sim_tconv_linearizer.sv
module sim_tconv_linearizer;

  localparam int PERIOD = 10;
  localparam int NVEC   = 10;
  // {ratio, alpha, gain, offset}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'd2458,  16'd16384, 16'd39040, 16'hB940},
    {16'd4915,  16'd16384, 16'd39040, 16'hB940},
    {16'd7373,  16'd16384, 16'd39040, 16'hB940},
    {16'd9830,  16'd16384, 16'd39040, 16'hB940},
    {16'd11796, 16'd16384, 16'd39040, 16'hB940},
    {16'd3000,  16'd15872, 16'd38416, 16'hB9E0},
    {16'd8000,  16'd15872, 16'd38416, 16'hB9E0},
    {16'd11000, 16'd15872, 16'd38416, 16'hB9E0},
    {16'd16384, 16'd16384, 16'd39040, 16'hB940},
    {16'd63898, 16'd1024,  16'd39040, 16'h0000}
  };
  localparam int NOMINAL_ROWS = 8;

  logic clk = 0, rstN = 0, inValid = 0;
  logic [15:0] ratioIn = 0, alphaIn = 0, gainIn = 0, offsetIn = 0;
  logic inReady, outValid;
  logic [15:0] tempOut;

  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  tconv_linearizer u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .ratioIn(ratioIn), .alphaIn(alphaIn), .gainIn(gainIn), .offsetIn(offsetIn),
    .outValid(outValid), .tempOut(tempOut)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expTemp(input longint x, input longint a,
                                     input longint g, input logic [15:0] b);
    longint den, mu, r, s;
    den = a * 16 + x;
    mu  = (den == 0) ? 64'h1FFFF : (a <<< 20) / den;
    r   = (g * mu + 32768) >>> 16;
    s   = r + longint'($signed(b));
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic startConv(input logic [15:0] x, input logic [15:0] a,
                           input logic [15:0] g, input logic [15:0] b);
    @(negedge clk);
    ratioIn = x; alphaIn = a; gainIn = g; offsetIn = b;
    // R2 idle before offering
    chk(inReady == 1'b1, "R2", inReady, 1);
    inValid = 1;
    @(posedge clk);
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic waitResult(output logic [15:0] got, output int lat);
    lat = 0;
    while (!outValid && lat < 100) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    got = tempOut;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] got, held;
    int lat;
    longint e;
    real mr, dr;

    // R1 reset state
    #(PERIOD * 3 + 2);
    chk(outValid == 0, "R1", outValid, 0);
    chk(inReady == 1, "R1", inReady, 1);
    chk(tempOut == 0, "R1", tempOut, 0);
    @(negedge clk); rstN = 1;
    repeat (2) @(negedge clk);
    chk(outValid == 0 && tempOut == 0, "R1", tempOut, 0);

    // Table walk: R4 R5 exact, R6 tolerance, R3 latency
    for (int i = 0; i < NVEC; i++) begin
      startConv(VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
      chk(inReady == 0, "R2", inReady, 0);
      waitResult(got, lat);
      chk(lat == 18, "R3", lat, 18);
      chk(inReady == 1, "R3", inReady, 1);
      e = expTemp(VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
      chk(longint'($signed(got)) == e, "R4 R5", $signed(got), e);
      if (i < NOMINAL_ROWS) begin
        mr = real'(VEC[i][47:32]) / 1024.0;
        mr = mr / (mr + real'(VEC[i][63:48]) / 16384.0);
        dr = real'(VEC[i][31:16]) / 64.0 * mr + real'($signed(VEC[i][15:0])) / 64.0;
        dr = dr * 64.0 - real'($signed(got));
        chk(dr <= 1.5 && dr >= -1.5, "R6", $signed(got), longint'(dr));
      end
      @(negedge clk);
      chk(outValid == 0, "R3", outValid, 1'b0);
    end

    // R7 alpha zero gives offset; ratio zero gives gain+offset
    startConv(16'd4915, 16'd0, 16'd39040, 16'hB940);
    waitResult(got, lat);
    chk($signed(got) == -18112, "R7", $signed(got), -18112);
    startConv(16'd0, 16'd16384, 16'd39040, 16'hB940);
    waitResult(got, lat);
    chk($signed(got) == 20928, "R7", $signed(got), 20928);

    // R8 positive clamp
    startConv(16'd0, 16'd16384, 16'hFFFF, 16'h7FC0);
    waitResult(got, lat);
    chk(got == 16'h7FFF, "R8", got, 16'h7FFF);
    // R8 most negative offset with zero gain
    startConv(16'd100, 16'd16384, 16'd0, 16'h8000);
    waitResult(got, lat);
    chk(got == 16'h8000, "R8", got, 16'h8000);

    // R11 hold between results
    held = tempOut;
    repeat (6) @(negedge clk);
    chk(tempOut == held && outValid == 0, "R11", tempOut, held);

    // R9 offers while busy are ignored
    startConv(16'd2458, 16'd16384, 16'd39040, 16'hB940);
    ratioIn = 16'd11796; inValid = 1;
    for (int k = 0; k < 5; k++) begin
      chk(inReady == 0, "R9", inReady, 0);
      @(negedge clk);
    end
    inValid = 0;
    waitResult(got, lat);
    e = expTemp(2458, 16384, 39040, 16'hB940);
    chk(longint'($signed(got)) == e, "R9", $signed(got), e);
    @(negedge clk);
    chk(outValid == 0 && inReady == 1, "R9", outValid, 0);

    // R10 calibration changes mid-conversion
    startConv(16'd7373, 16'd16384, 16'd39040, 16'hB940);
    alphaIn = 16'd8000; gainIn = 16'd20000; offsetIn = 16'h0100;
    waitResult(got, lat);
    e = expTemp(7373, 16384, 39040, 16'hB940);
    chk(longint'($signed(got)) == e, "R10", $signed(got), e);
    startConv(16'd7373, 16'd8000, 16'd20000, 16'h0100);
    waitResult(got, lat);
    e = expTemp(7373, 8000, 20000, 16'h0100);
    chk(longint'($signed(got)) == e, "R10", $signed(got), e);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule